// File: doc/BRIEF.md
# Ping-Pong Receive DMA Status Tracker

This block follows the receive side of a serial controller whose DMA engine alternates between two buffers, A and B. Software arms a buffer by loading it with a byte length. The tracker decides which buffer is taking bytes, counts the bytes written into it, and hands over to the other buffer when the active one is full. Bytes that arrive while no buffer can take them stay in the receive FIFO. If the FIFO is full at that moment, an overrun is held pending and charged to the buffer that next takes a byte.

Each buffer keeps sticky frame-error, parity-error and overrun flags. Frame and parity tags are honoured only in UART mode. In SPI slave mode, a chip-select release event latches the byte count of the active buffer into a saved-count register. A three-bit code records which buffer was sampled and whether this happened more than once since the code was last cleared. The flags, the code, two pass-through transmit-active inputs and the two receive-active bits are presented together as one 16-bit status word.

Top module: `rxdma_status_tracker`

## Requirements
- R1: After `rst` or a `dma_reset` cycle, the status word and `saved_count` are zero and buffer A is first in line. Status bits 15:13 always read zero.
- R2: A buffer that was loaded with a nonzero length is active only while it is first in line. Status bit 0 shows A active and bit 1 shows B active. At most one of the two is set. A load with length zero leaves that buffer inactive.
- R3: Each `byte_vld` while a buffer is active adds one to that buffer's count. When the count reaches the loaded length, the buffer goes inactive and the other buffer becomes first in line, and active if it is loaded. With no buffer active, no byte is counted.
- R4: In UART mode (`mode_spi`=0), a byte taken with `tag_frm` set sets the frame flag of the buffer that took it: bit 8 for A, bit 9 for B. The flag stays set until that same buffer is loaded or `dma_reset` is asserted. A load of the other buffer leaves it alone. In SPI mode, `tag_frm` has no effect.
- R5: The parity flags (bit 6 for A, bit 7 for B) follow the same rules as R4, driven by `tag_par`.
- R6: A `byte_vld` with no buffer active and `fifo_full` high raises a pending overrun, which is not yet visible in the status word. The next byte taken by either buffer sets that buffer's overrun flag (bit 4 for A, bit 5 for B) in either mode. These flags clear like the frame flags.
- R7: In SPI mode, `nssel_release` while a buffer is active copies that buffer's count from before the cycle into `saved_count`. It also sets the code in bits 12:10 to 2 for A or 3 for B. In UART mode, or with no buffer active, the event has no effect.
- R8: A further qualifying release before the code is cleared overwrites `saved_count`, sets the code to 6 for A or 7 for B, and records the buffer sampled most recently.
- R9: The code clears to 0 when either buffer is loaded or on `dma_reset`. A load in the same cycle as a release wins. Codes 1, 4 and 5 never appear.
- R10: Status bit 2 equals `tx_act_a` and bit 3 equals `tx_act_b`, in the same cycle.
- R11: `dma_reset` overrides loads and bytes that arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_reset | input | 1 | Receive DMA reset, synchronous |
| mode_spi | input | 1 | 0 = UART, 1 = SPI slave |
| load_a | input | 1 | Load strobe for buffer A |
| len_a | input | CNT_W | Byte length loaded into buffer A |
| load_b | input | 1 | Load strobe for buffer B |
| len_b | input | CNT_W | Byte length loaded into buffer B |
| byte_vld | input | 1 | A byte is offered by the receive FIFO |
| tag_frm | input | 1 | Offered byte has a frame error |
| tag_par | input | 1 | Offered byte has a parity error |
| fifo_full | input | 1 | Receive FIFO is full |
| nssel_release | input | 1 | Chip select has deasserted (one-cycle event) |
| tx_act_a | input | 1 | Transmit buffer A active |
| tx_act_b | input | 1 | Transmit buffer B active |
| status | output | 16 | Packed status word |
| saved_count | output | CNT_W | Count latched on chip-select release |

## Verification
The bench builds the tracker with `CNT_W` = 4. This makes the largest loadable length, 15, reachable in a few cycles, so a buffer can be filled to its upper limit and the handover checked at the counter's full range. Everything else runs at that width as well. Short lengths of 2 to 5 bytes drive the ping-pong handover, the overrun attribution and the repeated-release sequence through codes 2, 6 and 7 within a handful of cycles each.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int STAT_W = 16;

    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_sel_e;

    typedef struct packed {
        logic frm;
        logic par;
        logic ovr;
    } err_flags_t;

    // bit2: sampled more than once, bit1: a count is held, bit0: buffer B
    typedef struct packed {
        logic more;
        logic saved;
        logic is_b;
    } save_code_t;

    function automatic logic code_legal(input save_code_t c);
        return (c == 3'd0) || (c == 3'd2) || (c == 3'd3) ||
               (c == 3'd6) || (c == 3'd7);
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(
        input save_code_t code,
        input err_flags_t fa,
        input err_flags_t fb,
        input logic       tx_a,
        input logic       tx_b,
        input logic       rx_a,
        input logic       rx_b
    );
        logic [STAT_W-1:0] w;
        w        = '0;
        w[12:10] = code;
        w[9]     = fb.frm;
        w[8]     = fa.frm;
        w[7]     = fb.par;
        w[6]     = fa.par;
        w[5]     = fb.ovr;
        w[4]     = fa.ovr;
        w[3]     = tx_b;
        w[2]     = tx_a;
        w[1]     = rx_b;
        w[0]     = rx_a;
        return w;
    endfunction

endpackage

// File: rtl/rxdma_buf_slot.sv
module rxdma_buf_slot
    import rxdma_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             take,
    input  logic             tag_frm,
    input  logic             tag_par,
    input  logic             tag_ovr,
    output logic             armed,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output err_flags_t       flags
);

    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = count + 1'b1;
    assign done    = take && armed && !load && !clr && (cnt_inc == len_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed <= 1'b0;
            count <= '0;
            len_q <= '0;
            flags <= '0;
        end else if (load) begin
            armed <= (load_len != '0);
            len_q <= load_len;
            count <= '0;
            flags <= '0;
        end else if (take && armed) begin
            count     <= cnt_inc;
            flags.frm <= flags.frm | tag_frm;
            flags.par <= flags.par | tag_par;
            flags.ovr <= flags.ovr | tag_ovr;
            if (done) begin
                armed <= 1'b0;
            end
        end
    end

    assert_count_below_len_R3: assert property (@(posedge clk) disable iff (rst)
        armed |-> (count < len_q));

    assert_load_clears_R4: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> (count == '0) && (flags == '0));

    assert_frm_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (flags.frm && !load && !clr) |=> flags.frm);

    assert_par_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (flags.par && !load && !clr) |=> flags.par);

endmodule

// File: rtl/rxdma_rx_seq.sv
module rxdma_rx_seq
    import rxdma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic armed_a,
    input  logic armed_b,
    input  logic done_a,
    input  logic done_b,
    input  logic byte_vld,
    input  logic fifo_full,
    output logic act_a,
    output logic act_b,
    output logic take_a,
    output logic take_b,
    output logic pend_ovr
);

    buf_sel_e nxt_q;
    logic     none_active;

    assign act_a       = armed_a && (nxt_q == BUF_A);
    assign act_b       = armed_b && (nxt_q == BUF_B);
    assign none_active = !act_a && !act_b;
    assign take_a      = byte_vld && act_a;
    assign take_b      = byte_vld && act_b;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            nxt_q <= BUF_A;
        end else if (done_a || done_b) begin
            nxt_q <= (nxt_q == BUF_A) ? BUF_B : BUF_A;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend_ovr <= 1'b0;
        end else if (byte_vld && none_active && fifo_full) begin
            pend_ovr <= 1'b1;
        end else if (take_a || take_b) begin
            pend_ovr <= 1'b0;
        end
    end

    assert_single_active_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act_a, act_b}));

    assert_handover_a_R3: assert property (@(posedge clk) disable iff (rst)
        (done_a && !clr) |=> !act_a);

    assert_handover_b_R3: assert property (@(posedge clk) disable iff (rst)
        (done_b && !clr) |=> !act_b);

    assert_pend_consumed_R6: assert property (@(posedge clk) disable iff (rst)
        (pend_ovr && (take_a || take_b)) |=> !pend_ovr);

endmodule

// File: rtl/rxdma_save_trk.sv
module rxdma_save_trk
    import rxdma_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             any_load,
    input  logic             evt,
    input  logic             evt_is_b,
    input  logic [CNT_W-1:0] evt_cnt,
    output save_code_t       code,
    output logic [CNT_W-1:0] saved_cnt
);

    logic evt_eff;

    assign evt_eff = evt && !any_load;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code      <= '0;
            saved_cnt <= '0;
        end else begin
            if (any_load) begin
                code <= '0;
            end else if (evt_eff) begin
                code.more  <= code.saved;
                code.saved <= 1'b1;
                code.is_b  <= evt_is_b;
            end
            if (evt_eff) begin
                saved_cnt <= evt_cnt;
            end
        end
    end

    assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
        code_legal(code));

    assert_code_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(any_load || clr) |-> (code == '0));

    assert_repeat_sets_more_R8: assert property (@(posedge clk) disable iff (rst)
        (evt && !any_load && !clr && code.saved) |=> code.more);

    assert_first_save_R7: assert property (@(posedge clk) disable iff (rst)
        (evt && !any_load && !clr) |=> code.saved && (saved_cnt == $past(evt_cnt)));

endmodule

// File: rtl/rxdma_status_tracker.sv
module rxdma_status_tracker
    import rxdma_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_reset,
    input  logic              mode_spi,
    input  logic              load_a,
    input  logic [CNT_W-1:0]  len_a,
    input  logic              load_b,
    input  logic [CNT_W-1:0]  len_b,
    input  logic              byte_vld,
    input  logic              tag_frm,
    input  logic              tag_par,
    input  logic              fifo_full,
    input  logic              nssel_release,
    input  logic              tx_act_a,
    input  logic              tx_act_b,
    output logic [STAT_W-1:0] status,
    output logic [CNT_W-1:0]  saved_count
);

    localparam int NBUF = 2;

    logic [NBUF-1:0]  load_v;
    logic [CNT_W-1:0] len_v   [NBUF];
    logic [NBUF-1:0]  take_v;
    logic [NBUF-1:0]  armed_v;
    logic [NBUF-1:0]  done_v;
    logic [CNT_W-1:0] cnt_v   [NBUF];
    err_flags_t       flg_v   [NBUF];

    logic       act_a, act_b;
    logic       take_a, take_b;
    logic       pend_ovr;
    logic       uart_mode;
    logic       save_evt;
    save_code_t code;

    assign uart_mode = !mode_spi;
    assign load_v    = {load_b, load_a};
    assign len_v[0]  = len_a;
    assign len_v[1]  = len_b;
    assign take_v    = {take_b, take_a};

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        rxdma_buf_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .clr      (dma_reset),
            .load     (load_v[i]),
            .load_len (len_v[i]),
            .take     (take_v[i]),
            .tag_frm  (tag_frm && uart_mode),
            .tag_par  (tag_par && uart_mode),
            .tag_ovr  (pend_ovr),
            .armed    (armed_v[i]),
            .count    (cnt_v[i]),
            .done     (done_v[i]),
            .flags    (flg_v[i])
        );
    end

    rxdma_rx_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .clr       (dma_reset),
        .armed_a   (armed_v[0]),
        .armed_b   (armed_v[1]),
        .done_a    (done_v[0]),
        .done_b    (done_v[1]),
        .byte_vld  (byte_vld),
        .fifo_full (fifo_full),
        .act_a     (act_a),
        .act_b     (act_b),
        .take_a    (take_a),
        .take_b    (take_b),
        .pend_ovr  (pend_ovr)
    );

    assign save_evt = nssel_release && mode_spi && (act_a || act_b);

    rxdma_save_trk #(.CNT_W(CNT_W)) u_save (
        .clk       (clk),
        .rst       (rst),
        .clr       (dma_reset),
        .any_load  (load_a || load_b),
        .evt       (save_evt),
        .evt_is_b  (act_b),
        .evt_cnt   (act_b ? cnt_v[1] : cnt_v[0]),
        .code      (code),
        .saved_cnt (saved_count)
    );

    assign status = pack_status(code, flg_v[0], flg_v[1], tx_act_a, tx_act_b, act_a, act_b);

    assert_frm_uart_only_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(flg_v[0].frm) || $rose(flg_v[1].frm)) |-> $past(uart_mode));

    assert_par_uart_only_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(flg_v[0].par) || $rose(flg_v[1].par)) |-> $past(uart_mode));

    assert_dma_reset_wins_R11: assert property (@(posedge clk) disable iff (rst)
        $past(dma_reset) |-> (status[12:4] == '0) && !act_a && !act_b);

endmodule

// File: tb/tb_rxdma_status_tracker.sv
`timescale 1ns/1ps
module tb_rxdma_status_tracker;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          dma_reset, mode_spi;
    logic          load_a, load_b;
    logic [CW-1:0] len_a, len_b;
    logic          byte_vld, tag_frm, tag_par, fifo_full;
    logic          nssel_release, tx_act_a, tx_act_b;
    logic [15:0]   status;
    logic [CW-1:0] saved_count;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    rxdma_status_tracker #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .dma_reset(dma_reset), .mode_spi(mode_spi),
        .load_a(load_a), .len_a(len_a), .load_b(load_b), .len_b(len_b),
        .byte_vld(byte_vld), .tag_frm(tag_frm), .tag_par(tag_par),
        .fifo_full(fifo_full), .nssel_release(nssel_release),
        .tx_act_a(tx_act_a), .tx_act_b(tx_act_b),
        .status(status), .saved_count(saved_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        dma_reset = 0; load_a = 0; load_b = 0; byte_vld = 0;
        tag_frm = 0; tag_par = 0; fifo_full = 0; nssel_release = 0;
    endtask

    task automatic do_clear();
        dma_reset = 1;
        tick();
    endtask

    task automatic push(input logic frm, input logic par);
        byte_vld = 1; tag_frm = frm; tag_par = par;
        tick();
    endtask

    task automatic t_reset();
        rst = 1;
        tick(); tick();
        rst = 0;
        tick();
        chk("R1 status after reset", status, 0);
        chk("R1 saved count after reset", saved_count, 0);
    endtask

    task automatic t_pingpong();
        do_clear();
        load_a = 1; len_a = 3; load_b = 1; len_b = 2;
        tick();
        chk("R2 A active first", status[1:0], 2'b01);
        push(0, 0); push(0, 0);
        chk("R3 A still active", status[1:0], 2'b01);
        push(0, 0);
        chk("R3 handover to B", status[1:0], 2'b10);
        push(0, 0); push(0, 0);
        chk("R3 both done", status[1:0], 2'b00);
        byte_vld = 1; nssel_release = 1; mode_spi = 1;
        tick();
        mode_spi = 0;
        chk("R3 byte not counted when idle", status, 0);
    endtask

    task automatic t_zero_len();
        do_clear();
        load_a = 1; len_a = 0;
        tick();
        chk("R2 zero length stays inactive", status[1:0], 2'b00);
        load_b = 1; len_b = 2;
        tick();
        chk("R2 B waits while A first in line", status[1:0], 2'b00);
    endtask

    task automatic t_overrun_frame();
        do_clear();
        byte_vld = 1; fifo_full = 1;
        tick();
        chk("R6 pending overrun not visible", status, 0);
        load_b = 1; len_b = 2;
        tick();
        load_a = 1; len_a = 2;
        tick();
        chk("R2 A active", status, 16'h0001);
        push(0, 0);
        chk("R6 overrun charged to A", status, 16'h0011);
        push(0, 0);
        chk("R3 handover keeps A overrun", status, 16'h0012);
        push(1, 0);
        chk("R4 frame flag on B", status, 16'h0212);
        load_a = 1; len_a = 3;
        tick();
        chk("R4 load A clears A only", status, 16'h0202);
        load_b = 1; len_b = 3;
        tick();
        chk("R4 load B clears frame B", status[9:4], 0);
    endtask

    task automatic t_parity_mode();
        do_clear();
        load_a = 1; len_a = 4;
        tick();
        push(0, 1);
        chk("R5 parity flag on A", status, 16'h0041);
        mode_spi = 1;
        push(1, 1);
        chk("R4 frame ignored in SPI mode", status[8], 0);
        chk("R5 parity ignored in SPI mode", status[7:6], 2'b01);
        mode_spi = 0;
        load_a = 1; dma_reset = 1; byte_vld = 1;
        tick();
        chk("R11 dma reset beats load and byte", status, 0);
    endtask

    task automatic t_save();
        do_clear();
        mode_spi = 1;
        load_a = 1; len_a = 5; load_b = 1; len_b = 5;
        tick();
        push(0, 0); push(0, 0);
        nssel_release = 1;
        tick();
        chk("R7 code A once", status[12:10], 2);
        chk("R7 saved count A", saved_count, 2);
        push(0, 0);
        nssel_release = 1;
        tick();
        chk("R8 code A repeated", status[12:10], 6);
        chk("R8 saved count overwritten", saved_count, 3);
        push(0, 0); push(0, 0); push(0, 0);
        nssel_release = 1;
        tick();
        chk("R8 code B repeated", status[12:10], 7);
        chk("R8 saved count B", saved_count, 1);
        chk("R1 top bits zero", status[15:13], 0);
        load_a = 1; len_a = 5;
        tick();
        chk("R9 load clears code", status[12:10], 0);
        chk("R9 saved count kept", saved_count, 1);
        mode_spi = 0;
        nssel_release = 1;
        tick();
        chk("R7 release ignored in UART", status[12:10], 0);
        mode_spi = 1;
        nssel_release = 1; load_a = 1; len_a = 5;
        tick();
        chk("R9 load wins over release", status[12:10], 0);
        nssel_release = 1;
        tick();
        chk("R7 code B once", status[12:10], 3);
        dma_reset = 1;
        tick();
        chk("R1 dma reset clears code", status[12:10], 0);
        chk("R1 dma reset clears saved count", saved_count, 0);
        nssel_release = 1;
        tick();
        chk("R7 release with no active buffer", status[12:10], 0);
        mode_spi = 0;
    endtask

    task automatic t_max_len();
        do_clear();
        load_a = 1; len_a = 15;
        tick();
        for (int i = 0; i < 14; i++) push(0, 0);
        chk("R3 A active before max length", status[0], 1);
        push(0, 0);
        chk("R3 A done at max length", status[0], 0);
    endtask

    task automatic t_tx();
        tx_act_a = 1;
        #1;
        chk("R10 tx A bit", status[3:2], 2'b01);
        tx_act_b = 1; tx_act_a = 0;
        #1;
        chk("R10 tx B bit", status[3:2], 2'b10);
        tx_act_b = 0;
        #1;
        chk("R10 tx bits low", status[3:2], 2'b00);
    endtask

    initial begin
        #(4 * 200000);
        if (!ended) begin
            ended = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; dma_reset = 0; mode_spi = 0; load_a = 0; load_b = 0;
        len_a = 0; len_b = 0; byte_vld = 0; tag_frm = 0; tag_par = 0;
        fifo_full = 0; nssel_release = 0; tx_act_a = 0; tx_act_b = 0;
        t_reset();
        t_pingpong();
        t_zero_len();
        t_overrun_frame();
        t_parity_mode();
        t_save();
        t_max_len();
        t_tx();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule